// File: doc/BRIEF.md
# Memory-Indirect Preindexed Address Generator

This block computes a 32-bit operand address in two stages with a memory read between them. A start strobe captures the operands: a base register, an index register with size and scale selects, and two displacements that each carry a size code. Suppress flags can remove the base or the index. In the first stage the block adds the base displacement, the base register and the scaled index to form an intermediate pointer. It then reads one 32-bit word at that pointer through a request/acknowledge port.

In the second stage the block adds the outer displacement to the word it fetched. The result is presented on `ea` together with a single-cycle `done` pulse. Every component may be absent or suppressed, in which case it contributes zero. Every component is sign-extended to 32 bits before it is added, and all sums wrap modulo 2^32.

Top module: `mip_agu`

## Requirements
- R1: The read address equals base displacement + base register + scaled index, computed from the operands captured on the accepted start.
- R2: `rd_req` rises on the cycle after an accepted start. It stays high, with `rd_addr` unchanged, until the cycle on which `rd_ack` is sampled high, and drops on the following cycle.
- R3: On the cycle after `rd_ack` is sampled high, `done` is high for exactly one cycle. In that same cycle `ea` equals `rd_data` (as sampled with the acknowledge) plus the outer displacement. `ea` holds its value until the next `done`.
- R4: Each displacement size code selects the displacement's contribution: 2'b00 gives zero, 2'b01 gives the low 16 bits sign-extended, 2'b10 gives all 32 bits, and 2'b11 gives zero.
- R5: With `idx_long` = 0 the index contribution is the low 16 bits of `idx_val`, sign-extended. With `idx_long` = 1 all 32 bits are used.
- R6: `idx_scale` values 0, 1, 2 and 3 multiply the extended index by 1, 2, 4 and 8.
- R7: With `base_sup` high the base register contributes zero. With `idx_sup` high the index contributes zero.
- R8: All additions wrap modulo 2^32.
- R9: A start that arrives while a read is outstanding, including on the acknowledge cycle, is ignored and issues no extra read. A start on the cycle `done` is high is accepted.
- R10: After reset, `rd_req` and `done` are low and `ea` is zero.
- R11: All nine pairings of base and outer displacement sizes (null, word, long), which cover one to five extension words, give correct addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (ignored while busy) |
| base_val | input | 32 | Base register value |
| base_sup | input | 1 | Suppress base register |
| idx_val | input | 32 | Index register value |
| idx_long | input | 1 | 1: full 32-bit index, 0: low 16 bits sign-extended |
| idx_scale | input | 2 | Index shift amount 0..3 |
| idx_sup | input | 1 | Suppress index |
| bd_val | input | 32 | Base displacement value |
| bd_size | input | 2 | Base displacement size code |
| od_val | input | 32 | Outer displacement value |
| od_size | input | 2 | Outer displacement size code |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read address (intermediate pointer) |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 32 | Final effective address |

## Verification
Two events can coincide. One is the completion of one calculation, where `done` is high and the block has returned to idle. The other is the arrival of the next start. The bench waits for `done`, raises `start` in that same cycle, and expects a second read at the new intermediate address followed by a second correct result. It also drives a start exactly on the acknowledge cycle. For that start it expects no extra read request and an unchanged result.

// File: rtl/mip_pkg.sv
package mip_pkg;
  typedef enum logic [1:0] {
    DSZ_NULL = 2'b00,
    DSZ_WORD = 2'b01,
    DSZ_LONG = 2'b10,
    DSZ_RSVD = 2'b11
  } dsz_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } st_e;
endpackage

// File: rtl/mip_rst_sync.sv
module mip_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mip_sext.sv
module mip_sext #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic [W-1:0] val,
  input  logic         en,
  input  logic         long_sel,
  output logic [W-1:0] ext
);
  localparam int EXT_W = W - HW;

  logic [W-1:0] short_ext;
  assign short_ext = {{EXT_W{val[HW-1]}}, val[HW-1:0]};

  always_comb begin
    if (!en)          ext = '0;
    else if (long_sel) ext = val;
    else               ext = short_ext;
  end
endmodule

// File: rtl/mip_scaler.sv
module mip_scaler #(
  parameter int W  = 32,
  parameter int SW = 2
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] scale,
  output logic [W-1:0]  scaled
);
  localparam int NSTEP = 1 << SW;

  logic [W-1:0] cand [NSTEP];

  for (genvar g = 0; g < NSTEP; g++) begin : g_shift
    assign cand[g] = val << g;
  end

  assign scaled = cand[scale];
endmodule

// File: rtl/mip_ctrl.sv
module mip_ctrl
  import mip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rd_ack,
  output logic load_ptr,
  output logic load_ea,
  output logic rd_req,
  output logic done
);
  st_e  st_q, st_d;
  logic done_d;

  always_comb begin
    st_d     = st_q;
    load_ptr = 1'b0;
    load_ea  = 1'b0;
    done_d   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d     = ST_FETCH;
          load_ptr = 1'b1;
        end
      end
      ST_FETCH: begin
        if (rd_ack) begin
          st_d    = ST_IDLE;
          load_ea = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
    end
  end

  assign rd_req = (st_q == ST_FETCH);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req); // R2
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack |=> !rd_req); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_req && rd_ack)); // R3
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req); // R9
endmodule

// File: rtl/mip_agu.sv
module mip_agu
  import mip_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              base_sup,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic              idx_long,
  input  logic [SCALE_W-1:0] idx_scale,
  input  logic              idx_sup,
  input  logic [ADDR_W-1:0] bd_val,
  input  logic [1:0]        bd_size,
  input  logic [ADDR_W-1:0] od_val,
  input  logic [1:0]        od_size,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [ADDR_W-1:0] rd_data,
  output logic              done,
  output logic [ADDR_W-1:0] ea
);
  localparam int HALF_W = ADDR_W / 2;

  logic              rst_i_n;
  logic              load_ptr, load_ea;
  logic [ADDR_W-1:0] bd_ext, od_ext, idx_ext, idx_scaled, base_eff;
  logic [ADDR_W-1:0] ptr_d, ptr_q, od_q, ea_d, ea_q;
  logic              bd_en, bd_long, od_en, od_long;

  mip_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  assign bd_en   = (bd_size == DSZ_WORD) || (bd_size == DSZ_LONG);
  assign bd_long = (bd_size == DSZ_LONG);
  assign od_en   = (od_size == DSZ_WORD) || (od_size == DSZ_LONG);
  assign od_long = (od_size == DSZ_LONG);

  mip_sext #(.W(ADDR_W), .HW(HALF_W)) u_bd (
    .val(bd_val), .en(bd_en), .long_sel(bd_long), .ext(bd_ext)
  );
  mip_sext #(.W(ADDR_W), .HW(HALF_W)) u_od (
    .val(od_val), .en(od_en), .long_sel(od_long), .ext(od_ext)
  );
  mip_sext #(.W(ADDR_W), .HW(HALF_W)) u_idx (
    .val(idx_val), .en(!idx_sup), .long_sel(idx_long), .ext(idx_ext)
  );
  mip_scaler #(.W(ADDR_W), .SW(SCALE_W)) u_scl (
    .val(idx_ext), .scale(idx_scale), .scaled(idx_scaled)
  );

  mip_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .start(start), .rd_ack(rd_ack),
    .load_ptr(load_ptr), .load_ea(load_ea), .rd_req(rd_req), .done(done)
  );

  assign base_eff = base_sup ? '0 : base_val;
  assign ptr_d    = bd_ext + base_eff + idx_scaled;
  assign ea_d     = rd_data + od_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ptr_q <= '0;
      od_q  <= '0;
    end else if (load_ptr) begin
      ptr_q <= ptr_d;
      od_q  <= od_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) ea_q <= '0;
    else if (load_ea) ea_q <= ea_d;
  end

  assign rd_addr = ptr_q;
  assign ea      = ea_q;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_req && !rd_ack |=> $stable(rd_addr)); // R2
  AST_EA_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$stable(ea) |-> done); // R3
  AST_BUSY_START_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_req && start |=> $stable(rd_addr)); // R9
endmodule

// File: tb/sim_mip_agu.sv
module sim_mip_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_val = '0, idx_val = '0, bd_val = '0, od_val = '0;
  logic        base_sup = 1'b0, idx_long = 1'b0, idx_sup = 1'b0;
  logic [1:0]  idx_scale = '0, bd_size = '0, od_size = '0;
  logic        rd_req, done;
  logic [31:0] rd_addr, ea;
  logic        rd_ack = 1'b0;
  logic [31:0] rd_data = '0;

  int n_chk = 0, n_fail = 0, n_req = 0, n_push = 0, lat = 0;
  bit finished = 0;
  logic [31:0] exp_ptr[$];
  logic [31:0] exp_ea[$];

  always #10 clk = ~clk;

  mip_agu u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_val(base_val),
    .base_sup(base_sup), .idx_val(idx_val), .idx_long(idx_long),
    .idx_scale(idx_scale), .idx_sup(idx_sup), .bd_val(bd_val),
    .bd_size(bd_size), .od_val(od_val), .od_size(od_size),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .done(done), .ea(ea)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC3A5_0F96;
  endfunction

  function automatic logic [31:0] dext(logic [31:0] v, logic [1:0] s);
    case (s)
      2'b01:   return {{16{v[15]}}, v[15:0]};
      2'b10:   return v;
      default: return 32'h0;
    endcase
  endfunction

  // driver: set operands, compute expectation, push to scoreboard
  task automatic issue(logic [31:0] b, bit bs, logic [31:0] x, bit xl,
                       logic [1:0] sc, bit xs, logic [31:0] bd, logic [1:0] bsz,
                       logic [31:0] od, logic [1:0] osz);
    logic [31:0] xe, p;
    xe = xs ? 32'h0 : (xl ? x : {{16{x[15]}}, x[15:0]});
    p  = dext(bd, bsz) + (bs ? 32'h0 : b) + (xe << sc);
    exp_ptr.push_back(p);
    exp_ea.push_back(mem_word(p) + dext(od, osz));
    n_push++;
    base_val = b; base_sup = bs; idx_val = x; idx_long = xl; idx_scale = sc;
    idx_sup = xs; bd_val = bd; bd_size = bsz; od_val = od; od_size = osz;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (exp_ea.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // memory responder: checks address (R1/R2) and answers after lat cycles
  initial begin
    int cnt;
    bit in_req;
    logic [31:0] prev;
    cnt = 0; in_req = 0; prev = '0;
    forever begin
      @(negedge clk);
      if (rd_req && !rd_ack) begin
        if (!in_req) n_req++;
        else chk(rd_addr == prev, "R2 address held", rd_addr, prev);
        in_req = 1; prev = rd_addr;
        if (cnt >= lat) begin
          if (exp_ptr.size() == 0) chk(0, "R9 unexpected read", rd_addr, 32'h0);
          else begin
            logic [31:0] e;
            e = exp_ptr.pop_front();
            chk(rd_addr == e, "R1 intermediate address", rd_addr, e);
          end
          rd_ack = 1'b1; rd_data = mem_word(rd_addr);
        end else cnt++;
      end else begin
        rd_ack = 1'b0; rd_data = 32'hDEAD_BEEF; cnt = 0; in_req = 0;
      end
    end
  end

  // monitor: compares results against the scoreboard
  initial begin
    bit done_prev;
    done_prev = 0;
    forever begin
      @(negedge clk);
      if (done) begin
        chk(!done_prev, "R3 done single pulse", 32'(done_prev), 32'h0);
        if (exp_ea.size() == 0) chk(0, "R3 unexpected done", ea, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_ea.pop_front();
          chk(ea == e, "R3 effective address", ea, e);
        end
      end
      done_prev = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(rd_req == 1'b0, "R10 rd_req low", 32'(rd_req), 32'h0);
    chk(done == 1'b0, "R10 done low", 32'(done), 32'h0);
    chk(ea == 32'h0, "R10 ea zero", ea, 32'h0);

    // R11 / R4: all nine displacement size pairings
    for (int b = 0; b < 3; b++) begin
      for (int o = 0; o < 3; o++) begin
        lat = (b + o) % 3;
        issue(32'h0001_0000, 0, 32'h0000_0010, 0, 2'd1, 0,
              32'h5555_8123, 2'(b), 32'h7777_F00F, 2'(o));
        drain();
      end
    end
    // R4 reserved code contributes zero
    issue(32'h2000_0000, 0, 32'h4, 1, 2'd0, 0, 32'h1234_5678, 2'b11,
          32'h0BAD_0000, 2'b11);
    drain();
    // R5 word index sign-extended, R6 scale x8
    issue(32'h0000_1000, 0, 32'hABCD_FFFE, 0, 2'd3, 0, 0, 2'b00, 0, 2'b00);
    drain();
    // R5 long index, R6 scale x4 and x2
    issue(32'h0000_1000, 0, 32'h0001_0002, 1, 2'd2, 0, 0, 2'b00, 4, 2'b01);
    drain();
    issue(32'h0000_0100, 0, 32'hFFFF_FFF0, 1, 2'd1, 0, 32'h10, 2'b01, 0, 2'b00);
    drain();
    // R7 suppress base, then index
    issue(32'hFFFF_0000, 1, 32'h8, 1, 2'd0, 0, 32'h40, 2'b10, 0, 2'b00);
    drain();
    issue(32'h0300_0000, 0, 32'h8, 1, 2'd3, 1, 32'h40, 2'b10, 0, 2'b00);
    drain();
    // R8 wrap in both stages
    issue(32'hFFFF_FFF0, 0, 32'h0, 0, 2'd0, 1, 32'h0000_0020, 2'b01,
          32'h8000_0000, 2'b10);
    drain();

    // R9 start while busy and on ack cycle ignored
    lat = 6;
    issue(32'h0000_2000, 0, 32'h3, 1, 2'd2, 0, 32'h0, 2'b00, 32'h1, 2'b10);
    base_val = 32'h9999_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    do begin @(negedge clk); #1; end while (!rd_ack);
    base_val = 32'h7777_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    chk(rd_req == 1'b0, "R9 no extra read", 32'(rd_req), 32'h0);
    chk(n_req == n_push, "R9 read count", 32'(n_req), 32'(n_push));

    // R9 start on the done cycle accepted
    lat = 1;
    issue(32'h0000_4000, 0, 32'h1, 1, 2'd0, 0, 32'h2, 2'b01, 32'h3, 2'b01);
    while (!done) @(negedge clk);
    issue(32'h0000_5000, 0, 32'h2, 1, 2'd1, 0, 32'h4, 2'b01, 32'h5, 2'b01);
    drain();
    repeat (2) @(negedge clk);
    chk(n_req == n_push, "R9 back-to-back read count", 32'(n_req), 32'(n_push));
    chk(exp_ptr.size() == 0, "R1 all reads seen", 32'(exp_ptr.size()), 32'h0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule